// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block caches recent virtual-to-physical page translations for a 32-bit address. Every stored entry is compared at once against the virtual page number of a request. The comparison also uses the address-space identifier held in the high holding register, so translations that belong to several processes can stay resident together. An entry that carries the global flag matches under any identifier. The 12-bit page offset passes straight through. The top three address bits pick a segment. Two of the segments bypass translation entirely and differ only in whether the access may be cached.

Maintenance follows a software-refill model. Software loads a high holding register with the page number and identifier, and a low holding register with the frame number and flags. It then issues one of three operations. A probe searches the buffer and records the matching slot in the index register, or raises a fail flag. An indexed write stores the holding registers into the slot named by the index register. A random write stores them into the slot named by a free-running replacement counter, which never selects the protected low slots. The lookup outputs are combinational from the request. The maintenance operations take effect at the next clock edge.

Top module: `tlb_asid_top`

## Requirements
- R1: During and after synchronous active-low reset, random_q is 63, index_q is 0 and probe_fail_q is 0, and every entry is invalid, so a user request to address 0 raises rsp_refill.
- R2: random_q decrements by one on every clock edge out of reset and wraps from 8 (the first unprotected slot) to 63, so it always lies in 8..63.
- R3: An entry matches a mapped request when its page number equals req_va[31:12] and either its identifier equals the identifier in the high holding register or its global flag is set.
- R4: On a translated hit, rsp_pa is the entry's frame number followed by req_va[11:0] unchanged.
- R5: op_probe compares the high holding register against all entries, regardless of their valid flag. On a match it loads the lowest matching slot into index_q and clears probe_fail_q. With no match it sets probe_fail_q and leaves index_q unchanged.
- R6: op_wr_index writes the holding registers into slot index_q. op_wr_random writes them into the slot that random_q shows before that clock edge.
- R7: Segment decode uses req_va[31:29]: 0xx and 11x are translated, 100 is untranslated and cached, and 101 is untranslated and uncached. An untranslated hit gives rsp_pa = {3'b000, req_va[28:0]}. A translated hit sets rsp_cached to the inverse of the entry's no-cache flag.
- R8: A translated request with no matching entry, or whose matching entry has valid = 0, raises rsp_refill and not rsp_hit.
- R9: A store (req_store = 1) that matches a valid entry with dirty = 0 raises rsp_modify and not rsp_hit.
- R10: A user-mode request (req_user = 1) with req_va[31] = 1 raises rsp_addr_err alone. Whenever rsp_hit is 0, rsp_pa and rsp_cached are 0.
- R11: lo_flags_in packs the flags as bit 3 no-cache, bit 2 dirty, bit 1 valid, bit 0 global.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hi_we | input | 1 | Load high holding register |
| hi_vpn_in | input | 20 | Virtual page number for high register |
| hi_asid_in | input | 6 | Address-space identifier for high register |
| lo_we | input | 1 | Load low holding register |
| lo_pfn_in | input | 20 | Physical frame number for low register |
| lo_flags_in | input | 4 | Flags {no-cache, dirty, valid, global} |
| idx_we | input | 1 | Load index register from idx_in |
| idx_in | input | 6 | Index register write value |
| op_probe | input | 1 | Probe with high register contents |
| op_wr_index | input | 1 | Write holding registers at index_q |
| op_wr_random | input | 1 | Write holding registers at random_q |
| req_valid | input | 1 | Lookup request present |
| req_va | input | 32 | Request virtual address |
| req_store | input | 1 | Request is a store |
| req_user | input | 1 | Request made in user mode |
| rsp_hit | output | 1 | Access permitted, rsp_pa valid |
| rsp_pa | output | 32 | Physical address |
| rsp_cached | output | 1 | Access may be cached |
| rsp_refill | output | 1 | Missing or invalid translation |
| rsp_modify | output | 1 | Store to clean page |
| rsp_addr_err | output | 1 | User access to kernel half |
| index_q | output | 6 | Index register |
| probe_fail_q | output | 1 | Last probe found no entry |
| random_q | output | 6 | Replacement slot counter |

## Verification
Lookups are tried against one page number under two identifiers, so that identifier mismatch is told apart from page mismatch, while a global entry must hit under any identifier. Loads and stores to clean and dirty pages separate the modify outcome from a plain hit. An invalid entry is distinguished from an absent one. Addresses in each of the four segments, in both user and kernel mode, separate untranslated, uncached, translated and address-error results, including the top offset of the cached window. Probes hit a global entry, an invalid entry and a protected slot, and one probe misses, which shows that the index is retained on failure. A random write is followed by a probe that has to return the counter value the bench predicted.

// File: rtl/tlb_pkg.sv
// Shared widths and entry layout for the translation buffer.
// Assumes a 32-bit virtual address split into page number and offset.
package tlb_pkg;
    parameter int VPN_W  = 20;
    parameter int PFN_W  = 20;
    parameter int ASID_W = 6;
    parameter int OFF_W  = 12;
    localparam int VA_W  = VPN_W + OFF_W;
    localparam int PA_W  = PFN_W + OFF_W;

    typedef struct packed {
        logic nc;   // no-cache
        logic d;    // dirty (writable)
        logic v;    // valid
        logic g;    // global: ignore identifier
    } tlb_flags_t;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PFN_W-1:0]  pfn;
        tlb_flags_t        flags;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_random.sv
// Replacement slot counter: steps down once per clock across the
// unprotected slots and wraps from the lowest back to the highest.
// Assumes WIRED < ENTRIES.
module tlb_random #(
    parameter int ENTRIES = 64,
    parameter int WIRED   = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [IDX_W-1:0] slot_q
);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1);
    localparam logic [IDX_W-1:0] LOW = IDX_W'(WIRED);

    // Count down, wrap from the lowest free slot to the top.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot_q <= TOP;
        else if (slot_q == LOW)
            slot_q <= TOP;
        else
            slot_q <= slot_q - 1'b1;
    end

    AST_RAND_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q >= LOW) && (slot_q <= TOP)); // R2
    AST_RAND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q != LOW) |=> (slot_q == $past(slot_q) - 1'b1)); // R2
endmodule

// File: rtl/tlb_segdec.sv
// Segment decode of the top three address bits and mode check.
// Assumes the kernel half is the top half of the address space.
module tlb_segdec (
    input  logic [2:0] seg_bits,
    input  logic       user,
    output logic       mapped,
    output logic       uncached,
    output logic       addr_err
);
    // Classify the segment and flag user access to the kernel half.
    always_comb begin
        addr_err = user && seg_bits[2];
        mapped   = !seg_bits[2] || seg_bits[1];
        uncached = (seg_bits == 3'b101);
    end
endmodule

// File: rtl/tlb_cam.sv
// Entry storage with two parallel match ports (lookup and probe),
// both qualified by the current identifier. Lowest matching slot wins.
// Assumes software keeps page numbers unique per identifier.
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  tlb_entry_t        wdata,
    input  logic [ASID_W-1:0] asid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [VPN_W-1:0]  pr_vpn,
    output logic              lk_any,
    output logic [PFN_W-1:0]  lk_pfn,
    output tlb_flags_t        lk_flags,
    output logic              pr_any,
    output logic [IDX_W-1:0]  pr_idx
);
    tlb_entry_t         mem [ENTRIES];
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] pr_match;
    logic [IDX_W-1:0]   lk_idx;

    // Store an entry; reset leaves every slot empty and invalid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        logic id_ok;
        assign id_ok       = mem[e].flags.g || (mem[e].asid == asid);
        assign lk_match[e] = id_ok && (mem[e].vpn == lk_vpn);
        assign pr_match[e] = id_ok && (mem[e].vpn == pr_vpn);
    end

    // Priority-encode both match vectors toward the lowest slot.
    always_comb begin
        lk_any = 1'b0;
        pr_any = 1'b0;
        lk_idx = '0;
        pr_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (lk_match[i]) begin
                lk_any = 1'b1;
                lk_idx = IDX_W'(i);
            end
            if (pr_match[i]) begin
                pr_any = 1'b1;
                pr_idx = IDX_W'(i);
            end
        end
    end

    // Read out the selected lookup entry.
    always_comb begin
        lk_pfn   = mem[lk_idx].pfn;
        lk_flags = mem[lk_idx].flags;
    end

    AST_PROBE_SLOT_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        pr_any |-> pr_match[pr_idx]); // R5
    AST_NO_MATCH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_any |-> (lk_match == '0)); // R8
endmodule

// File: rtl/tlb_asid_top.sv
// Translation buffer top: holding registers, index/fail register,
// lookup response logic and maintenance operation dispatch.
// Assumes at most one of op_probe/op_wr_index/op_wr_random per cycle.
module tlb_asid_top
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int WIRED   = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_we,
    input  logic [VPN_W-1:0]  hi_vpn_in,
    input  logic [ASID_W-1:0] hi_asid_in,
    input  logic              lo_we,
    input  logic [PFN_W-1:0]  lo_pfn_in,
    input  logic [3:0]        lo_flags_in,
    input  logic              idx_we,
    input  logic [IDX_W-1:0]  idx_in,
    input  logic              op_probe,
    input  logic              op_wr_index,
    input  logic              op_wr_random,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic              req_store,
    input  logic              req_user,
    output logic              rsp_hit,
    output logic [PA_W-1:0]   rsp_pa,
    output logic              rsp_cached,
    output logic              rsp_refill,
    output logic              rsp_modify,
    output logic              rsp_addr_err,
    output logic [IDX_W-1:0]  index_q,
    output logic              probe_fail_q,
    output logic [IDX_W-1:0]  random_q
);
    logic [VPN_W-1:0]  hi_vpn_q;
    logic [ASID_W-1:0] hi_asid_q;
    logic [PFN_W-1:0]  lo_pfn_q;
    tlb_flags_t        lo_flags_q;
    tlb_entry_t        wr_entry;
    logic              lk_any, pr_any;
    logic [PFN_W-1:0]  lk_pfn;
    tlb_flags_t        lk_flags;
    logic [IDX_W-1:0]  pr_idx;
    logic              seg_mapped, seg_uncached, seg_err;

    // Load the software holding registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_vpn_q   <= '0;
            hi_asid_q  <= '0;
            lo_pfn_q   <= '0;
            lo_flags_q <= '0;
        end else begin
            if (hi_we) begin
                hi_vpn_q  <= hi_vpn_in;
                hi_asid_q <= hi_asid_in;
            end
            if (lo_we) begin
                lo_pfn_q   <= lo_pfn_in;
                lo_flags_q <= tlb_flags_t'(lo_flags_in);
            end
        end
    end

    // Index register: software load, overridden by a successful probe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q      <= '0;
            probe_fail_q <= 1'b0;
        end else begin
            if (idx_we) index_q <= idx_in;
            if (op_probe) begin
                probe_fail_q <= !pr_any;
                if (pr_any) index_q <= pr_idx;
            end
        end
    end

    assign wr_entry = '{vpn: hi_vpn_q, asid: hi_asid_q, pfn: lo_pfn_q, flags: lo_flags_q};

    tlb_random #(.ENTRIES(ENTRIES), .WIRED(WIRED)) i_random (
        .clk    (clk),
        .rst_n  (rst_n),
        .slot_q (random_q)
    );

    tlb_cam #(.ENTRIES(ENTRIES)) i_cam (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (op_wr_index || op_wr_random),
        .waddr    (op_wr_index ? index_q : random_q),
        .wdata    (wr_entry),
        .asid     (hi_asid_q),
        .lk_vpn   (req_va[VA_W-1:OFF_W]),
        .pr_vpn   (hi_vpn_q),
        .lk_any   (lk_any),
        .lk_pfn   (lk_pfn),
        .lk_flags (lk_flags),
        .pr_any   (pr_any),
        .pr_idx   (pr_idx)
    );

    tlb_segdec i_segdec (
        .seg_bits (req_va[VA_W-1:VA_W-3]),
        .user     (req_user),
        .mapped   (seg_mapped),
        .uncached (seg_uncached),
        .addr_err (seg_err)
    );

    // Resolve one outcome per request and form the physical address.
    always_comb begin
        rsp_hit      = 1'b0;
        rsp_pa       = '0;
        rsp_cached   = 1'b0;
        rsp_refill   = 1'b0;
        rsp_modify   = 1'b0;
        rsp_addr_err = 1'b0;
        if (req_valid) begin
            if (seg_err) begin
                rsp_addr_err = 1'b1;
            end else if (!seg_mapped) begin
                rsp_hit    = 1'b1;
                rsp_pa     = {3'b000, req_va[VA_W-4:0]};
                rsp_cached = !seg_uncached;
            end else if (!lk_any || !lk_flags.v) begin
                rsp_refill = 1'b1;
            end else if (req_store && !lk_flags.d) begin
                rsp_modify = 1'b1;
            end else begin
                rsp_hit    = 1'b1;
                rsp_pa     = {lk_pfn, req_va[OFF_W-1:0]};
                rsp_cached = !lk_flags.nc;
            end
        end
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_hit, rsp_refill, rsp_modify, rsp_addr_err})); // R8
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_pa[OFF_W-1:0] == req_va[OFF_W-1:0])); // R4
    AST_AERR_USER: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_addr_err |-> (req_user && req_va[VA_W-1])); // R10
    AST_MODIFY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_modify |-> req_store); // R9
    AST_PROBE_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_probe && !pr_any) |=> (probe_fail_q && $stable(index_q))); // R5
    AST_RAND_WRITE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        op_wr_random |-> (random_q >= IDX_W'(WIRED))); // R6
    AST_UNMAPPED_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && !seg_mapped) |-> (rsp_pa[PA_W-1:PA_W-3] == 3'b000)); // R7
endmodule

// File: tb/test_tlb_asid_top.sv
module test_tlb_asid_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hi_we = 0, lo_we = 0, idx_we = 0;
    logic [19:0] hi_vpn_in = 0, lo_pfn_in = 0;
    logic [5:0]  hi_asid_in = 0, idx_in = 0;
    logic [3:0]  lo_flags_in = 0;
    logic        op_probe = 0, op_wr_index = 0, op_wr_random = 0;
    logic        req_valid = 0, req_store = 0, req_user = 0;
    logic [31:0] req_va = 0;
    logic        rsp_hit, rsp_cached, rsp_refill, rsp_modify, rsp_addr_err;
    logic [31:0] rsp_pa;
    logic [5:0]  index_q, random_q;
    logic        probe_fail_q;

    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;  // 50 MHz

    tlb_asid_top i_tlb_asid_top (.*);

    typedef struct packed {
        logic [5:0]  asid;
        logic [31:0] va;
        logic        st, usr;
        logic [4:0]  res;   // {hit, refill, modify, addr_err, cached}
        logic [31:0] pa;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{6'd5, 32'h00400ABC, 1'b0, 1'b1, 5'b10001, 32'h12345ABC}, // R4
        '{6'd5, 32'h00400ABC, 1'b1, 1'b1, 5'b10001, 32'h12345ABC}, // R9 dirty store
        '{6'd5, 32'h00401010, 1'b0, 1'b1, 5'b01000, 32'h0},        // R3 asid diff
        '{6'd5, 32'h00402FFF, 1'b0, 1'b1, 5'b10001, 32'h00777FFF}, // R3 global
        '{6'd5, 32'h00403000, 1'b0, 1'b0, 5'b01000, 32'h0},        // R8 invalid
        '{6'd5, 32'h00500000, 1'b0, 1'b0, 5'b01000, 32'h0},        // R8 absent
        '{6'd5, 32'h80001234, 1'b0, 1'b0, 5'b10001, 32'h00001234}, // R7 cached
        '{6'd5, 32'hA0005678, 1'b1, 1'b0, 5'b10000, 32'h00005678}, // R7 uncached
        '{6'd5, 32'h80001234, 1'b0, 1'b1, 5'b00010, 32'h0},        // R10
        '{6'd5, 32'hC0000040, 1'b0, 1'b0, 5'b10001, 32'h22222040}, // R7 mapped kernel
        '{6'd5, 32'hC0000040, 1'b1, 1'b1, 5'b00010, 32'h0},        // R10
        '{6'd5, 32'h9FFFFFFF, 1'b0, 1'b0, 5'b10001, 32'h1FFFFFFF}, // R7 window top
        '{6'd7, 32'h00401010, 1'b0, 1'b1, 5'b10000, 32'h0ABCD010}, // R3 R7 no-cache
        '{6'd7, 32'h00401010, 1'b1, 1'b1, 5'b00100, 32'h0},        // R9 clean store
        '{6'd7, 32'h00400ABC, 1'b0, 1'b1, 5'b01000, 32'h0}         // R3 other asid
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic set_hi(input logic [19:0] vpn, input logic [5:0] asid);
        @(negedge clk);
        hi_we = 1; hi_vpn_in = vpn; hi_asid_in = asid;
        @(negedge clk);
        hi_we = 0;
    endtask

    task automatic write_slot(input logic [5:0] slot, input logic [19:0] vpn,
                              input logic [5:0] asid, input logic [19:0] pfn,
                              input logic [3:0] flg);
        @(negedge clk);
        hi_we = 1; hi_vpn_in = vpn; hi_asid_in = asid;
        lo_we = 1; lo_pfn_in = pfn; lo_flags_in = flg;
        idx_we = 1; idx_in = slot;
        @(negedge clk);
        hi_we = 0; lo_we = 0; idx_we = 0;
        op_wr_index = 1;
        @(negedge clk);
        op_wr_index = 0;
    endtask

    task automatic probe(input logic [19:0] vpn, input logic [5:0] asid);
        set_hi(vpn, asid);
        op_probe = 1;
        @(negedge clk);
        op_probe = 0;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [5:0] exp_r;
        logic [5:0] seen_r;
        logic [5:0] cur_asid;
        // Reset state
        repeat (3) @(negedge clk);
        req_valid = 1; req_user = 1; req_va = 32'h0;
        #1;
        check("R1 random", {26'd0, random_q}, 32'd63);
        check("R1 index", {26'd0, index_q}, 32'd0);
        check("R1 fail", {31'd0, probe_fail_q}, 32'd0);
        check("R1 empty refill", {27'd0, rsp_hit, rsp_refill, rsp_modify, rsp_addr_err, rsp_cached},
              32'b01000);
        req_valid = 0;
        rst_n = 1;
        // Random counter sequence across two wraps
        exp_r = 6'd63;
        for (int k = 0; k < 120; k++) begin
            @(negedge clk);
            exp_r = (exp_r == 6'd8) ? 6'd63 : exp_r - 6'd1;
            check("R2 random step", {26'd0, random_q}, {26'd0, exp_r});
        end
        // Fill entries (flags {nc,d,v,g}, R11)
        write_slot(6'd8,  20'h00400, 6'd5, 20'h12345, 4'b0110);
        write_slot(6'd9,  20'h00401, 6'd7, 20'h0ABCD, 4'b1010);
        write_slot(6'd10, 20'h00402, 6'd0, 20'h00777, 4'b0111);
        write_slot(6'd11, 20'h00403, 6'd5, 20'h11111, 4'b0100);
        write_slot(6'd20, 20'hC0000, 6'd5, 20'h22222, 4'b0111);
        // Vector table walk
        cur_asid = 6'h3F;
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].asid != cur_asid) begin
                set_hi(20'h0, VEC[i].asid);
                cur_asid = VEC[i].asid;
            end
            @(negedge clk);
            req_valid = 1; req_va = VEC[i].va; req_store = VEC[i].st; req_user = VEC[i].usr;
            #1;
            check($sformatf("R3-table row %0d outcome", i),
                  {27'd0, rsp_hit, rsp_refill, rsp_modify, rsp_addr_err, rsp_cached},
                  {27'd0, VEC[i].res});
            check($sformatf("R4/R10 row %0d pa", i), rsp_pa, VEC[i].pa);
        end
        req_valid = 0;
        // No request: all outputs quiet
        #1;
        check("R10 idle quiet", {26'd0, rsp_hit, rsp_refill, rsp_modify, rsp_addr_err, rsp_cached},
              32'd0);
        // Probes (R5)
        probe(20'h00401, 6'd7);
        check("R5 probe asid hit idx", {26'd0, index_q}, 32'd9);
        check("R5 probe asid hit fail", {31'd0, probe_fail_q}, 32'd0);
        probe(20'h00402, 6'd3);
        check("R5 probe global idx", {26'd0, index_q}, 32'd10);
        probe(20'h77777, 6'd3);
        check("R5 probe miss fail", {31'd0, probe_fail_q}, 32'd1);
        check("R5 probe miss idx kept", {26'd0, index_q}, 32'd10);
        probe(20'h00403, 6'd5);
        check("R5 probe invalid entry idx", {26'd0, index_q}, 32'd11);
        check("R5 probe fail cleared", {31'd0, probe_fail_q}, 32'd0);
        // Indexed write into a protected slot (R6)
        write_slot(6'd0, 20'h55555, 6'd5, 20'h66666, 4'b0110);
        probe(20'h55555, 6'd5);
        check("R6 indexed write slot 0", {26'd0, index_q}, 32'd0);
        // Random write (R6)
        @(negedge clk);
        hi_we = 1; hi_vpn_in = 20'h33333; hi_asid_in = 6'd5;
        lo_we = 1; lo_pfn_in = 20'h44444; lo_flags_in = 4'b0110;
        @(negedge clk);
        hi_we = 0; lo_we = 0;
        seen_r = random_q;
        op_wr_random = 1;
        @(negedge clk);
        op_wr_random = 0;
        probe(20'h33333, 6'd5);
        check("R6 random write slot", {26'd0, index_q}, {26'd0, seen_r});
        @(negedge clk);
        req_valid = 1; req_va = 32'h33333008; req_store = 0; req_user = 1;
        #1;
        check("R6 random entry translates", rsp_pa, 32'h44444008);
        req_valid = 0;
        finish_run();
    end
endmodule